// File: doc/BRIEF.md
# Buffered Auto-Reload Interval Timer

This block is a down-counting interval timer on a small word-addressed register bus. Software places a period in a count buffer word. That value is held there until software writes the shared control word with the update bit set. The write copies the buffer into the latched reload value and into the live counter, and it does not start the timer. A later control write with the start bit set, and the update bit clear, loads the counter from the latched reload value and sets it running.

While the timer runs, the counter steps down once for every clock on which `tick_en` is high. A prescaler outside the block supplies that enable. When the count expires, the block raises `irq` for exactly one clock. If the auto-reload bit of the control word is set at that moment, the counter refills from the reload value and keeps running. If the bit is clear, the counter stops at zero. Software reads the live count through a separate observation word. Every other index reads back the word last stored there.

Top module: `buffered_interval_timer`

## Requirements
- R1: A synchronous active-high reset clears every stored word, the reload value and the counter, and stops the timer. After reset `irq` is 0 and every read returns 0.
- R2: The word index is `bus_addr[6:2]`, and `bus_addr[1:0]` are ignored. A write to index 0 to 15 stores the full 32-bit word. A read presents the word at index 0 to 15 on `bus_rdata` one clock after the address is applied.
- R3: Writing the count buffer (index 15) leaves the counter unchanged. A write to the control word (index 2) with bit 21 set copies the buffer into both the reload value and the counter, and it does not start a stopped timer.
- R4: A write to the control word with bit 21 clear and bit 20 set loads the counter from the reload value and starts the timer.
- R5: A running counter decrements by one on each clock with `tick_en` high and holds its value on clocks with `tick_en` low.
- R6: A counter expires on the tick taken at a count of 1, or on the first tick when the count is 0. `irq` is high for the single clock after that tick and low at all other times.
- R7: At expiry with control bit 22 set, the counter reloads from the reload value and keeps running. At expiry with bit 22 clear, the counter becomes 0 and stops.
- R8: A read of index 16 returns the live counter value as it stood at the clock edge where the address was sampled.
- R9: Writes to index 16 and to indices 17 to 31 have no effect, and reads of indices 17 to 31 return 0.
- R10: A write to the control word with bits 20 and 21 both clear stops the timer, and the counter holds its value.
- R11: A control write that arrives in the same clock as a tick takes priority. The tick is discarded, and no expiry occurs in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address; bits [6:2] select the word |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| tick_en | input | 1 | Count enable from the external prescaler |
| irq | output | 1 | One-clock pulse on each expiry |

## Verification
A behavioural model in the bench predicts `bus_rdata` and `irq` on every clock. The bench runs the following patterns:

- Continuous ticks in one-shot mode show whether expiry happens at the count of 1 and whether the counter stops at zero.
- Gapped ticks separate decrementing from holding.
- Auto-reload with periods of 3 and of 0 shows whether the refill value and the spacing between pulses are right.
- A start write that coincides with a tick shows whether the control write takes priority.
- Buffer writes and manual updates made while the timer runs, with pseudo-random tick patterns, show whether the update bit reaches the counter without starting it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Commands decoded from one write to the control word.
  typedef struct packed {
    logic update;  // copy count buffer into reload value and counter
    logic start;   // load counter from reload value and run
    logic stop;    // halt counting, hold value
  } tmr_cmd_t;

endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 17,
  parameter int IDX_W     = 5,
  parameter int CTRL_IDX  = 2,
  parameter int BUF_IDX   = 15,
  parameter int OBS_IDX   = 16,
  parameter int AUTO_BIT  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] obs_val,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] buf_word,
  output logic              auto_en
);

  localparam logic [IDX_W:0] NUM_EXT = (IDX_W+1)'(NUM_WORDS);
  localparam logic [IDX_W-1:0] OBS_SEL = IDX_W'(OBS_IDX);

  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] rd_sel;
  logic              in_range;

  assign in_range = ({1'b0, idx} < NUM_EXT);

  // One flop word per index; the observation slot holds no storage.
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == OBS_IDX) begin : g_obs
      assign words[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst) begin
          words[g] <= '0;
        end else if (wr_en && idx == IDX_W'(g)) begin
          words[g] <= wdata;
        end
      end
    end
  end

  assign buf_word = words[BUF_IDX];
  assign auto_en  = words[CTRL_IDX][AUTO_BIT];

  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx == IDX_W'(w)) rd_sel = words[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (idx == OBS_SEL) begin
      rdata <= obs_val;
    end else if (in_range) begin
      rdata <= rd_sel;
    end else begin
      rdata <= '0;
    end
  end

  // Checks
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IDX_W'(BUF_IDX)) |=> (buf_word == $past(wdata)));

  p_obs_read_r8: assert property (@(posedge clk) disable iff (rst)
    (idx == OBS_SEL) |=> (rdata == $past(obs_val)));

  p_high_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_range) |=> (rdata == '0));

endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
  parameter int IDX_W    = 5,
  parameter int CTRL_IDX = 2
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic              upd_bit,
  input  logic              start_bit,
  output tmr_pkg::tmr_cmd_t cmd
);

  logic ctrl_wr;

  assign ctrl_wr = wr_en && (idx == IDX_W'(CTRL_IDX));

  // Update outranks start; a control write with neither bit stops.
  always_comb begin
    cmd.update = ctrl_wr && upd_bit;
    cmd.start  = ctrl_wr && !upd_bit && start_bit;
    cmd.stop   = ctrl_wr && !upd_bit && !start_bit;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  tmr_pkg::tmr_cmd_t cmd,
  input  logic [DATA_W-1:0] buf_word,
  input  logic              auto_en,
  output logic [DATA_W-1:0] count,
  output logic              irq
);

  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] reload_q;
  logic              run_q;
  logic              cmd_any;
  logic              expire;

  assign cmd_any = cmd.update | cmd.start | cmd.stop;
  assign expire  = run_q && tick_en && !cmd_any && (count_q <= DATA_W'(1));
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= expire;
      if (cmd.update) begin
        reload_q <= buf_word;
        count_q  <= buf_word;
      end else if (cmd.start) begin
        count_q <= reload_q;
        run_q   <= 1'b1;
      end else if (cmd.stop) begin
        run_q <= 1'b0;
      end else if (run_q && tick_en) begin
        if (expire) begin
          if (auto_en) begin
            count_q <= reload_q;
          end else begin
            count_q <= '0;
            run_q   <= 1'b0;
          end
        end else begin
          count_q <= count_q - DATA_W'(1);
        end
      end
    end
  end

  // Checks
  p_update_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.update |=> (count_q == $past(buf_word) && run_q == $past(run_q)));

  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    cmd.start |=> (run_q && count_q == $past(reload_q)));

  p_decrement_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_en && !cmd_any && count_q > DATA_W'(1))
      |=> (count_q == $past(count_q) - DATA_W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cmd_any) |=> $stable(count_q));

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run_q && tick_en));

  p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && !auto_en) |=> (!run_q && count_q == '0));

  p_autoreload_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && auto_en) |=> (run_q && count_q == $past(reload_q)));

  p_stop_r10: assert property (@(posedge clk) disable iff (rst)
    cmd.stop |=> (!run_q && $stable(count_q)));

  p_cmd_priority_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_any && tick_en) |=> !irq);

endmodule

// File: rtl/buffered_interval_timer.sv
module buffered_interval_timer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 7,
  parameter int NUM_WORDS = 17,
  parameter int CTRL_IDX  = 2,
  parameter int BUF_IDX   = 15,
  parameter int OBS_IDX   = 16,
  parameter int START_BIT = 20,
  parameter int UPD_BIT   = 21,
  parameter int AUTO_BIT  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              irq
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_byte_lane;
  logic [DATA_W-1:0] buf_word;
  logic [DATA_W-1:0] live_count;
  logic              auto_en;
  tmr_pkg::tmr_cmd_t cmd;

  assign idx              = bus_addr[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr[1:0];

  tmr_regfile #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
    .CTRL_IDX(CTRL_IDX), .BUF_IDX(BUF_IDX), .OBS_IDX(OBS_IDX),
    .AUTO_BIT(AUTO_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .idx(idx), .wdata(bus_wdata),
    .obs_val(live_count), .rdata(bus_rdata), .buf_word(buf_word),
    .auto_en(auto_en)
  );

  tmr_cmd_decode #(
    .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)
  ) u_dec (
    .wr_en(bus_wr), .idx(idx), .upd_bit(bus_wdata[UPD_BIT]),
    .start_bit(bus_wdata[START_BIT]), .cmd(cmd)
  );

  tmr_counter #(
    .DATA_W(DATA_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cmd(cmd),
    .buf_word(buf_word), .auto_en(auto_en), .count(live_count), .irq(irq)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0));

endmodule

// File: tb/tb_buffered_interval_timer.sv
module tb_buffered_interval_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_mem [0:16];
  logic [31:0] m_reload, m_count, m_rd;
  logic        m_run, m_irq;

  always #10 clk = ~clk;

  buffered_interval_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic compare(input string tag);
    n_chk++;
    if (bus_rdata !== m_rd) begin
      n_bad++;
      $display("FAIL %s rdata actual %h expected %h", tag, bus_rdata, m_rd);
    end
    n_chk++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, m_irq);
    end
  endtask

  // Drive one clock of stimulus, advance the model, compare after the edge.
  task automatic cyc(input logic [6:0] a, input logic we, input logic [31:0] d,
                     input logic tk, input string tag);
    int idx;
    logic [31:0] nrd;
    logic nirq;
    bus_addr = a; bus_wr = we; bus_wdata = d; tick_en = tk;
    idx = int'(a[6:2]);
    if (idx == 16) nrd = m_count;
    else if (idx < 17) nrd = m_mem[idx];
    else nrd = '0;
    nirq = 1'b0;
    if (we && idx == 2) begin
      if (d[21]) begin m_reload = m_mem[15]; m_count = m_mem[15]; end
      else if (d[20]) begin m_count = m_reload; m_run = 1'b1; end
      else m_run = 1'b0;
    end else if (m_run && tk) begin
      if (m_count <= 32'd1) begin
        nirq = 1'b1;
        if (m_mem[2][22]) m_count = m_reload;
        else begin m_count = '0; m_run = 1'b0; end
      end else begin
        m_count = m_count - 32'd1;
      end
    end
    if (we && idx < 16) m_mem[idx] = d;
    m_rd = nrd; m_irq = nirq;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic tk, input string tag);
    cyc({idx[4:0], 2'b00}, 1'b1, d, tk, tag);
  endtask

  task automatic rd(input int idx, input logic tk, input string tag);
    cyc({idx[4:0], 2'b00}, 1'b0, 32'h0, tk, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 17; i++) m_mem[i] = '0;
    m_reload = '0; m_count = '0; m_run = 1'b0; m_rd = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset outputs");
    rd(2, 1'b0, "R1 ctrl after reset");
    rd(15, 1'b0, "R1 buffer after reset");
    rd(16, 1'b1, "R1 count after reset");

    // R2: store and read back, byte-lane bits set
    cyc({5'd0, 2'b11}, 1'b1, 32'hA5A5_0001, 1'b0, "R2 write idx0");
    cyc({5'd1, 2'b10}, 1'b1, 32'h1234_5678, 1'b0, "R2 write idx1");
    cyc({5'd14, 2'b01}, 1'b1, 32'hDEAD_BEEF, 1'b0, "R2 write idx14");
    cyc({5'd0, 2'b01}, 1'b0, 32'h0, 1'b0, "R2 read idx0");
    rd(1, 1'b0, "R2 read idx1");
    rd(14, 1'b0, "R2 read idx14");

    // R9: ignored writes and zero reads
    wr(16, 32'hFFFF_FFFF, 1'b0, "R9 write obs");
    rd(16, 1'b0, "R9 obs unchanged");
    wr(20, 32'hCAFE_F00D, 1'b0, "R9 write idx20");
    rd(20, 1'b0, "R9 idx20 reads zero");
    rd(31, 1'b0, "R9 idx31 reads zero");

    // R3: buffer write does not touch counter; update copies, no start
    wr(15, 32'd5, 1'b1, "R3 buffer write");
    rd(16, 1'b0, "R3 counter untouched");
    wr(2, 32'h0020_0000, 1'b1, "R3 manual update");
    rd(16, 1'b1, "R3 count loaded");
    rd(16, 1'b1, "R3 no start after update");
    rd(2, 1'b0, "R3 ctrl word stored");

    // R4/R5/R6/R7: start one-shot, gapped ticks, expiry, stop at zero
    wr(2, 32'h0010_0000, 1'b0, "R4 start");
    for (int i = 0; i < 12; i++) rd(16, logic'(i % 3 != 2), "R5 gapped ticks");
    for (int i = 0; i < 4; i++) rd(16, 1'b1, "R7 one-shot stopped");

    // R7: auto-reload with period 3
    wr(15, 32'd3, 1'b0, "R7 buffer 3");
    wr(2, 32'h0060_0000, 1'b0, "R7 update with auto");
    wr(2, 32'h0050_0000, 1'b0, "R7 start auto");
    for (int i = 0; i < 10; i++) rd(16, 1'b1, "R7 auto period 3");

    // R10: stop holds value
    wr(2, 32'h0040_0000, 1'b1, "R10 stop");
    for (int i = 0; i < 3; i++) rd(16, 1'b1, "R10 held");

    // R6: reload 0 expires on first tick, every tick in auto mode
    wr(15, 32'd0, 1'b0, "R6 buffer 0");
    wr(2, 32'h0060_0000, 1'b0, "R6 update 0");
    wr(2, 32'h0050_0000, 1'b0, "R6 start 0");
    for (int i = 0; i < 4; i++) rd(16, 1'b1, "R6 zero reload");

    // R11: control write together with tick
    wr(15, 32'd1, 1'b1, "R11 buffer 1");
    wr(2, 32'h0060_0000, 1'b1, "R11 update with tick");
    wr(2, 32'h0050_0000, 1'b1, "R11 start with tick");
    rd(16, 1'b1, "R11 first expiry");
    rd(16, 1'b0, "R11 idle");

    // R5/R3: pseudo-random ticks with buffer changes while running
    lfsr = 16'hACE1;
    wr(15, 32'd7, 1'b0, "R5 buffer 7");
    wr(2, 32'h0060_0000, 1'b0, "R5 update 7");
    wr(2, 32'h0050_0000, 1'b0, "R5 start 7");
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 60 == 30) wr(15, {28'd0, lfsr[7:4]}, lfsr[0], "R3 buffer while running");
      else if (i % 60 == 31) wr(2, 32'h0060_0000, lfsr[1], "R3 update while running");
      else if (i % 7 == 3) rd(15, lfsr[0], "R5 random ticks buffer read");
      else rd(16, lfsr[0], "R5 random ticks");
    end

    summary();
    $finish;
  end

endmodule